// File: doc/BRIEF.md
# Adaptive Lock-Elision Predictor

This block decides, per lock, whether an acquire should first try to run its critical section as a hardware transaction, or take the lock straight away. Every lock maps to a slot, and the caller supplies the slot index. Each slot holds a confidence level from 0 to 10 and a count of plain acquisitions since the slot last tried elision. Successful transactions lower the level. Aborted ones raise it. A higher level makes the slot wait through more plain acquisitions before it tries again.

After an acquire opens a transactional attempt, the block runs a bounded retry loop. A soft abort costs one of five tries. A hard abort, or running out of tries, sends the caller to the real lock. The caller reports when its transaction has begun, and whether it saw the lock already held at that point. If the lock was held, the block asks for an explicit abort with code 1. A static policy input picks one of two ways to recover after a success lowers the level. The aggressive policy tries elision again at once. The conservative policy first waits through the new level's count of plain rounds. Four saturating counters report soft aborts, hard aborts, successful elisions and plain acquisitions.

Top module: `lep_predictor`

## Requirements
- R1: Each soft or hard abort (result code 1 or 2) raises the active slot's level by one, and a success (result code 0) lowers it by one. The level stays within 0 to 10.
- R2: An acquire on a slot at level 0 gives `dec_valid`=1 with `dec_elide`=1 on the cycle after `acq_req`.
- R3: On a slot at level L>0 with no pending boost, each acquire that takes the lock counts one plain round. Every acquire gives `dec_valid`=1 one cycle after `acq_req`. An attempt (`dec_elide`=1) comes only once 2^L-1 plain rounds have passed since the slot's last attempt. Starting an attempt clears the count.
- R4: With `aggressive`=1, a success that lowers the level arms the slot, and the slot's next acquire attempts elision whatever its level.
- R5: With `aggressive`=0, after a success lowers the level to L', the slot takes exactly 2^L'-1 plain rounds before its next attempt.
- R6: Within one acquire there are at most 5 tries. A soft abort before the fifth try gives `dec_valid`=1 with `dec_elide`=1 (retry) one cycle later. The fifth soft abort, or any hard abort, gives `dec_valid`=1 with `dec_elide`=0 (take the lock) and ends the acquire. A success ends the acquire with no decision pulse. Result code 3 has no effect.
- R7: During an attempt, `txn_begun` together with `lock_held` raises `xabort_req` with `xabort_code`=1 on the next cycle. At any other time both stay 0.
- R8: `cnt_soft`, `cnt_hard`, `cnt_ok` and `cnt_plain` count soft aborts, hard aborts, successes and lock takes. Lock takes include fallbacks after aborts. Each counter updates one cycle after its event.
- R9: The statistics counters stop at all-ones instead of wrapping.
- R10: After reset every slot is at level 0 with no plain rounds counted and no boost, all counters read 0, and `dec_valid` and `xabort_req` are low.
- R11: While an acquire is in progress, `acq_req` is ignored: no decision comes out and no counter or slot changes.
- R12: A slot at level 10 stays at 10 after a further abort, and it then still needs 1023 plain rounds per attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aggressive | input | 1 | 1 = retry at once after a level drop, 0 = wait through the new level's rounds |
| acq_req | input | 1 | Acquire request, taken only when idle |
| acq_slot | input | $clog2(NSLOT) | Slot index of the lock being acquired |
| txn_begun | input | 1 | The transaction of the current attempt has started |
| lock_held | input | 1 | The lock was seen held, sampled with `txn_begun` |
| res_valid | input | 1 | Transaction outcome is valid |
| res_kind | input | 2 | 0 success, 1 soft abort, 2 hard abort, 3 no effect |
| dec_valid | output | 1 | Decision pulse |
| dec_elide | output | 1 | 1 = try elision, 0 = take the lock |
| xabort_req | output | 1 | Explicit abort request |
| xabort_code | output | CODEW | Abort code, 1 while requested |
| cnt_soft | output | STATW | Soft abort count |
| cnt_hard | output | STATW | Hard abort count |
| cnt_ok | output | STATW | Successful elision count |
| cnt_plain | output | STATW | Lock-taking count |

## Verification
A wrong level, round count or boost bit in a slot does not show up until that slot's next attempt. The attempt then lands earlier or later than the expected acquire, on the `dec_elide` pulse one cycle after `acq_req`. So the bench counts the plain rounds between attempts, up to level 10, and it also runs a long mixed sequence against an arithmetic model of every slot. A broken retry counter shows on the first fallback, where the lock comes too early or too late. A broken statistics counter shows one cycle after the event that should have moved it.

// File: rtl/lep_pkg.sv
package lep_pkg;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_SOFT = 2'd1,
        RES_HARD = 2'd2,
        RES_NONE = 2'd3
    } lep_res_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TRY  = 1'b1
    } lep_state_e;

    localparam int STAT_SOFT  = 0;
    localparam int STAT_HARD  = 1;
    localparam int STAT_OK    = 2;
    localparam int STAT_PLAIN = 3;
    localparam int NUM_STATS  = 4;

    typedef logic [NUM_STATS-1:0] lep_inc_t;

    // plain rounds a slot at level lvl must see before it retries
    function automatic logic [31:0] lep_gap_limit(input int unsigned lvl);
        return (32'd1 << lvl) - 32'd1;
    endfunction

endpackage

// File: rtl/lep_slot_table.sv
module lep_slot_table #(
    parameter int NSLOT   = 8,
    parameter int MAX_LVL = 10,
    parameter int LVLW    = 4,
    parameter int GAPW    = 10,
    localparam int IDXW   = $clog2(NSLOT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] rd_idx,
    output logic [LVLW-1:0] rd_lvl,
    output logic [GAPW-1:0] rd_gap,
    output logic            rd_boost,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [LVLW-1:0] wr_lvl,
    input  logic [GAPW-1:0] wr_gap,
    input  logic            wr_boost
);
    logic [LVLW-1:0] lvl_q   [NSLOT];
    logic [GAPW-1:0] gap_q   [NSLOT];
    logic            boost_q [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) begin
                lvl_q[i]   <= '0;
                gap_q[i]   <= '0;
                boost_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            lvl_q[wr_idx]   <= wr_lvl;
            gap_q[wr_idx]   <= wr_gap;
            boost_q[wr_idx] <= wr_boost;
        end
    end

    assign rd_lvl   = lvl_q[rd_idx];
    assign rd_gap   = gap_q[rd_idx];
    assign rd_boost = boost_q[rd_idx];

    // R12
    wr_lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_lvl <= LVLW'(MAX_LVL)));

endmodule

// File: rtl/lep_decide.sv
module lep_decide
    import lep_pkg::*;
#(
    parameter int LVLW = 4,
    parameter int GAPW = 10
) (
    input  logic [LVLW-1:0] lvl,
    input  logic [GAPW-1:0] gap,
    input  logic            boost,
    output logic            go
);
    logic [31:0] gap_wide;
    logic [31:0] limit;

    always_comb begin
        gap_wide = 32'(gap);
        limit    = lep_gap_limit(32'(lvl));
        go       = (lvl == '0) || boost || (gap_wide >= limit);
    end

endmodule

// File: rtl/lep_stats.sv
module lep_stats
    import lep_pkg::*;
#(
    parameter int STATW = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  lep_inc_t                        inc,
    output logic [NUM_STATS-1:0][STATW-1:0] cnt
);
    for (genvar g = 0; g < NUM_STATS; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (inc[g] && (cnt[g] != {STATW{1'b1}})) begin
                cnt[g] <= cnt[g] + 1'b1;
            end
        end

        // R9
        stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt[g] == {STATW{1'b1}}) |=> (cnt[g] == {STATW{1'b1}}));

        // R8
        stat_step_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt[g] != {STATW{1'b1}}) |=>
                ((cnt[g] == $past(cnt[g])) || (cnt[g] == $past(cnt[g]) + 1'b1)));
    end

endmodule

// File: rtl/lep_predictor.sv
module lep_predictor
    import lep_pkg::*;
#(
    parameter int NSLOT      = 8,
    parameter int MAX_LVL    = 10,
    parameter int MAX_TRIES  = 5,
    parameter int STATW      = 16,
    parameter int CODEW      = 8,
    parameter int ABORT_CODE = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     aggressive,
    input  logic                     acq_req,
    input  logic [$clog2(NSLOT)-1:0] acq_slot,
    input  logic                     txn_begun,
    input  logic                     lock_held,
    input  logic                     res_valid,
    input  logic [1:0]               res_kind,
    output logic                     dec_valid,
    output logic                     dec_elide,
    output logic                     xabort_req,
    output logic [CODEW-1:0]         xabort_code,
    output logic [STATW-1:0]         cnt_soft,
    output logic [STATW-1:0]         cnt_hard,
    output logic [STATW-1:0]         cnt_ok,
    output logic [STATW-1:0]         cnt_plain
);
    localparam int IDXW = $clog2(NSLOT);
    localparam int LVLW = $clog2(MAX_LVL + 1);
    localparam int GAPW = MAX_LVL;
    localparam int TRYW = $clog2(MAX_TRIES + 1);

    lep_state_e      state_q, state_d;
    logic [IDXW-1:0] slot_q, slot_d;
    logic [TRYW-1:0] try_q, try_d;
    logic            dec_v_q, dec_v_d, dec_e_q, dec_e_d;
    logic            xab_q, xab_d;
    lep_res_e        res_e;

    logic [IDXW-1:0] rd_idx;
    logic [LVLW-1:0] rd_lvl, wr_lvl, lvl_up;
    logic [GAPW-1:0] rd_gap, wr_gap;
    logic            rd_boost, wr_boost, wr_en, go;
    lep_inc_t        inc;
    logic [NUM_STATS-1:0][STATW-1:0] cnt;

    assign res_e  = lep_res_e'(res_kind);
    assign rd_idx = (state_q == ST_IDLE) ? acq_slot : slot_q;
    assign lvl_up = (rd_lvl == LVLW'(MAX_LVL)) ? rd_lvl : rd_lvl + 1'b1;

    lep_slot_table #(
        .NSLOT(NSLOT), .MAX_LVL(MAX_LVL), .LVLW(LVLW), .GAPW(GAPW)
    ) u_table (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_lvl(rd_lvl), .rd_gap(rd_gap), .rd_boost(rd_boost),
        .wr_en(wr_en), .wr_idx(slot_d), .wr_lvl(wr_lvl), .wr_gap(wr_gap),
        .wr_boost(wr_boost)
    );

    lep_decide #(.LVLW(LVLW), .GAPW(GAPW)) u_decide (
        .lvl(rd_lvl), .gap(rd_gap), .boost(rd_boost), .go(go)
    );

    lep_stats #(.STATW(STATW)) u_stats (
        .clk(clk), .rst(rst), .inc(inc), .cnt(cnt)
    );

    always_comb begin
        state_d  = state_q;
        slot_d   = slot_q;
        try_d    = try_q;
        dec_v_d  = 1'b0;
        dec_e_d  = 1'b0;
        wr_en    = 1'b0;
        wr_lvl   = rd_lvl;
        wr_gap   = rd_gap;
        wr_boost = rd_boost;
        inc      = '0;
        xab_d    = (state_q == ST_TRY) && txn_begun && lock_held;

        if (state_q == ST_IDLE) begin
            if (acq_req) begin
                slot_d  = acq_slot;
                wr_en   = 1'b1;
                dec_v_d = 1'b1;
                if (go) begin
                    dec_e_d  = 1'b1;
                    wr_gap   = '0;
                    wr_boost = 1'b0;
                    try_d    = TRYW'(1);
                    state_d  = ST_TRY;
                end else begin
                    wr_gap = (rd_gap == {GAPW{1'b1}}) ? rd_gap : rd_gap + 1'b1;
                    inc[STAT_PLAIN] = 1'b1;
                end
            end
        end else if (res_valid) begin
            case (res_e)
                RES_OK: begin
                    inc[STAT_OK] = 1'b1;
                    wr_en        = 1'b1;
                    if (rd_lvl != '0) begin
                        wr_lvl   = rd_lvl - 1'b1;
                        wr_boost = aggressive;
                    end
                    state_d = ST_IDLE;
                end
                RES_SOFT: begin
                    inc[STAT_SOFT] = 1'b1;
                    wr_en          = 1'b1;
                    wr_lvl         = lvl_up;
                    dec_v_d        = 1'b1;
                    if (try_q == TRYW'(MAX_TRIES)) begin
                        inc[STAT_PLAIN] = 1'b1;
                        state_d         = ST_IDLE;
                    end else begin
                        dec_e_d = 1'b1;
                        try_d   = try_q + 1'b1;
                    end
                end
                RES_HARD: begin
                    inc[STAT_HARD]  = 1'b1;
                    inc[STAT_PLAIN] = 1'b1;
                    wr_en           = 1'b1;
                    wr_lvl          = lvl_up;
                    dec_v_d         = 1'b1;
                    state_d         = ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            try_q   <= '0;
            dec_v_q <= 1'b0;
            dec_e_q <= 1'b0;
            xab_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            try_q   <= try_d;
            dec_v_q <= dec_v_d;
            dec_e_q <= dec_e_d;
            xab_q   <= xab_d;
        end
    end

    assign dec_valid   = dec_v_q;
    assign dec_elide   = dec_e_q;
    assign xabort_req  = xab_q;
    assign xabort_code = xab_q ? CODEW'(ABORT_CODE) : '0;
    assign cnt_soft    = cnt[STAT_SOFT];
    assign cnt_hard    = cnt[STAT_HARD];
    assign cnt_ok      = cnt[STAT_OK];
    assign cnt_plain   = cnt[STAT_PLAIN];

    // R2
    lvl0_elide_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && acq_req && rd_lvl == '0) |=> (dec_valid && dec_elide));

    // R7
    xabort_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRY && txn_begun && lock_held) |=> xabort_req);

    // R1
    lvl_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_lvl == rd_lvl) || (wr_lvl == rd_lvl + 1'b1) || (wr_lvl + 1'b1 == rd_lvl)));

    // R6
    try_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRY) |-> ((try_q >= TRYW'(1)) && (try_q <= TRYW'(MAX_TRIES))));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRY && !res_valid) |=> !dec_valid);

endmodule

// File: tb/lep_predictor_test.sv
module lep_predictor_test;
    import lep_pkg::*;

    localparam int NS  = 4;
    localparam int SW  = 8;
    localparam int ML  = 10;
    localparam int MT  = 5;
    localparam int CW  = 8;
    localparam int SLW = $clog2(NS);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst, aggressive, acq_req, txn_begun, lock_held, res_valid;
    logic [SLW-1:0] acq_slot;
    logic [1:0]     res_kind;
    logic           dec_valid, dec_elide, xabort_req;
    logic [CW-1:0]  xabort_code;
    logic [SW-1:0]  cnt_soft, cnt_hard, cnt_ok, cnt_plain;

    lep_predictor #(
        .NSLOT(NS), .MAX_LVL(ML), .MAX_TRIES(MT), .STATW(SW), .CODEW(CW), .ABORT_CODE(1)
    ) uut (
        .clk(clk), .rst(rst), .aggressive(aggressive), .acq_req(acq_req),
        .acq_slot(acq_slot), .txn_begun(txn_begun), .lock_held(lock_held),
        .res_valid(res_valid), .res_kind(res_kind), .dec_valid(dec_valid),
        .dec_elide(dec_elide), .xabort_req(xabort_req), .xabort_code(xabort_code),
        .cnt_soft(cnt_soft), .cnt_hard(cnt_hard), .cnt_ok(cnt_ok), .cnt_plain(cnt_plain)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_lvl [NS];
    int m_gap [NS];
    bit m_boost [NS];
    int m_soft, m_hard, m_ok, m_plain;
    bit in_sess;
    int m_try, m_slot;
    int smax = (1 << SW) - 1;
    int gmax = (1 << ML) - 1;
    int unsigned seed = 32'h1234_5678;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sinc(input int v);
        return (v >= smax) ? smax : v + 1;
    endfunction

    function automatic int rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return int'(seed & 32'h7fff_ffff);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_lvl[i] = 0; m_gap[i] = 0; m_boost[i] = 0;
        end
        m_soft = 0; m_hard = 0; m_ok = 0; m_plain = 0;
        in_sess = 0; m_try = 0; m_slot = 0;
    endtask

    task automatic do_reset(input bit aggr);
        @(negedge clk);
        rst = 1; aggressive = aggr; acq_req = 0; acq_slot = '0; txn_begun = 0;
        lock_held = 0; res_valid = 0; res_kind = 2'd0;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic check_stats(input string req);
        check(req, int'(cnt_soft), m_soft);
        check(req, int'(cnt_hard), m_hard);
        check(req, int'(cnt_ok), m_ok);
        check(req, int'(cnt_plain), m_plain);
    endtask

    task automatic acquire(input int s, output bit el);
        int    exp;
        string tag;
        exp = (m_lvl[s] == 0 || m_boost[s] || m_gap[s] >= (1 << m_lvl[s]) - 1) ? 1 : 0;
        tag = (m_lvl[s] == 0) ? "R2" : (m_boost[s] ? "R4" : "R3");
        @(negedge clk);
        acq_req = 1; acq_slot = SLW'(s);
        @(negedge clk);
        acq_req = 0;
        check(tag, int'(dec_valid), 1);
        check(tag, int'(dec_elide), exp);
        el = dec_elide;
        if (exp == 1) begin
            m_gap[s] = 0; m_boost[s] = 0; in_sess = 1; m_try = 1; m_slot = s;
        end else begin
            m_gap[s] = (m_gap[s] >= gmax) ? gmax : m_gap[s] + 1;
            m_plain  = sinc(m_plain);
        end
    endtask

    task automatic result(input lep_res_e k);
        int    edv, ede, s;
        string tag;
        s = m_slot; edv = 0; ede = 0; tag = "R6";
        case (k)
            RES_OK: begin
                tag  = "R1";
                m_ok = sinc(m_ok);
                if (m_lvl[s] > 0) begin
                    m_lvl[s]--;
                    if (aggressive) m_boost[s] = 1;
                end
                in_sess = 0;
            end
            RES_SOFT: begin
                m_soft   = sinc(m_soft);
                m_lvl[s] = (m_lvl[s] >= ML) ? ML : m_lvl[s] + 1;
                edv      = 1;
                if (m_try == MT) begin
                    m_plain = sinc(m_plain); in_sess = 0;
                end else begin
                    m_try++; ede = 1;
                end
            end
            RES_HARD: begin
                m_hard   = sinc(m_hard);
                m_plain  = sinc(m_plain);
                m_lvl[s] = (m_lvl[s] >= ML) ? ML : m_lvl[s] + 1;
                edv      = 1;
                in_sess  = 0;
            end
            default: ;
        endcase
        @(negedge clk);
        res_valid = 1; res_kind = k;
        @(negedge clk);
        res_valid = 0; res_kind = 2'd0;
        check(tag, int'(dec_valid), edv);
        check(tag, int'(dec_elide), ede);
        check_stats("R8");
    endtask

    task automatic probe(input bit held);
        int exp;
        exp = (held && in_sess) ? 1 : 0;
        @(negedge clk);
        txn_begun = 1; lock_held = held;
        @(negedge clk);
        txn_begun = 0; lock_held = 0;
        check("R7", int'(xabort_req), exp);
        check("R7", int'(xabort_code), exp);
    endtask

    task automatic count_plain(input int s, output int n);
        bit e;
        n = 0;
        for (int k = 0; k < 3000; k++) begin
            acquire(s, e);
            if (e) break;
            n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit e;
        int n, p0;

        // R10 reset state
        do_reset(1'b0);
        @(negedge clk);
        check("R10", int'(dec_valid), 0);
        check("R10", int'(xabort_req), 0);
        check_stats("R10");
        probe(1'b1);

        // R6 five soft aborts then fallback; R7 explicit abort
        acquire(0, e);
        probe(1'b1);
        probe(1'b0);
        result(RES_NONE);
        for (int i = 0; i < MT; i++) result(RES_SOFT);

        // R11 request ignored mid-acquire
        acquire(1, e);
        p0 = int'(cnt_plain);
        @(negedge clk);
        acq_req = 1; acq_slot = SLW'(2);
        @(negedge clk);
        acq_req = 0;
        check("R11", int'(dec_valid), 0);
        check("R11", int'(cnt_plain), p0);
        result(RES_OK);
        acquire(2, e);
        check("R11", int'(e), 1);
        result(RES_OK);

        // R3 level 5 waits 31 rounds; R1 hard abort to level 6
        count_plain(0, n);
        check("R3", n, 31);
        result(RES_HARD);
        count_plain(0, n);
        check("R1", n, 63);
        // R5 conservative recovery
        result(RES_OK);
        count_plain(0, n);
        check("R5", n, 31);
        result(RES_OK);
        count_plain(0, n);
        check("R5", n, 15);
        result(RES_OK);

        // R4 aggressive recovery
        do_reset(1'b1);
        acquire(2, e);
        result(RES_SOFT);
        result(RES_SOFT);
        result(RES_OK);
        count_plain(2, n);
        check("R4", n, 0);
        result(RES_OK);
        acquire(2, e);
        for (int i = 0; i < MT; i++) result(RES_SOFT);
        count_plain(2, n);
        check("R3", n, 31);
        result(RES_OK);
        count_plain(2, n);
        check("R4", n, 0);
        result(RES_HARD);
        count_plain(2, n);
        check("R3", n, 31);
        result(RES_OK);

        // R12 saturation at level 10; R9 counter saturation
        do_reset(1'b0);
        acquire(3, e);
        for (int i = 0; i < MT; i++) result(RES_SOFT);
        count_plain(3, n);
        check("R3", n, 31);
        for (int i = 0; i < MT; i++) result(RES_SOFT);
        count_plain(3, n);
        check("R12", n, 1023);
        result(RES_HARD);
        count_plain(3, n);
        check("R12", n, 1023);
        result(RES_OK);
        check("R9", int'(cnt_plain), smax);

        // mixed sweep against the model, both policies
        for (int mode = 0; mode < 2; mode++) begin
            do_reset(mode[0]);
            for (int it = 0; it < 1500; it++) begin
                acquire(rnd() % NS, e);
                while (in_sess) begin
                    int r;
                    r = rnd() % 16;
                    if (r % 5 == 0) probe(r[0]);
                    if (r < 7)       result(RES_OK);
                    else if (r < 13) result(RES_SOFT);
                    else if (r < 15) result(RES_HARD);
                    else             result(RES_NONE);
                end
            end
            check_stats("R8");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule